// File: doc/BRIEF.md
# Serial Message Loader with Length Header

This block takes a secret message from an asynchronous serial line and hands each message byte to an on-chip message RAM through a simple write port. The line carries frames of one start bit, eight data bits and one stop bit. The receiver runs from the system clock and advances only on a sample tick that pulses at sixteen times the bit rate, for example 9600 baud. The block does not generate that tick.

The first two bytes on the line form a length header, high byte first. Every byte after the header is a message byte. It goes to the next RAM location, starting at address 0. When the announced number of message bytes has been written, a level embed flag rises and tells the downstream embedding engine to start. The flag stays high until reset. Once the flag is high, more traffic on the line causes no further writes.

A frame whose stop bit reads low is dropped. The block reports it with a one-cycle framing-error pulse and then waits for the next start bit.

Top module: `msg_loader`

## Requirements
- R1: After reset, embedGo, ramWrEn and frameErr are all 0.
- R2: A start bit is accepted only if the line is still low eight sample ticks after the falling edge is seen. Each data bit is then sampled once every sixteen ticks, least significant bit first, and the result is the byte value.
- R3: A low pulse shorter than half a bit period on an idle line produces no byte, no write and no framing error.
- R4: The first two correctly framed bytes after reset form the message length. The first is the high byte and the second is the low byte. Neither byte is written to the RAM.
- R5: Each message byte causes exactly one write on the RAM port (ramWrEn high for one cycle). Addresses count up by one from 0, and the data is the received byte.
- R6: embedGo stays 0 until the last announced message byte has been written. It is 1 from then until reset.
- R7: A length of zero raises embedGo right after the header, with no RAM write.
- R8: A length larger than the parameter MSG_DEPTH (default 8192) is reduced to MSG_DEPTH, so exactly MSG_DEPTH bytes are written.
- R9: A frame whose stop bit samples low is discarded. It produces frameErr high for exactly one cycle and no write. The frame that follows is received normally.
- R10: Once embedGo is 1, later frames cause no RAM writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| sampleTick | input | 1 | One-cycle pulse at 16x the bit rate |
| ramWrAddr | output | $clog2(MSG_DEPTH) | Message RAM write address |
| ramWrData | output | 8 | Message RAM write data |
| ramWrEn | output | 1 | Message RAM write enable, one cycle per byte |
| embedGo | output | 1 | Level flag: the whole message is stored |
| frameErr | output | 1 | One-cycle pulse on a frame with a low stop bit |

## Verification
The bench sends data bytes with the top or bottom bit set alone. A receiver that shifted in the wrong direction would store mirrored values. A short low glitch comes before a real frame, so a design that skipped the midpoint check of the start bit would either store a phantom byte or lose alignment with the frame that follows. The bench checks the embed flag one byte before the end, and it sends a zero length and a length above the RAM depth. An off-by-one count would raise the flag early or late, and a missing clamp would never raise it. A bad stop bit in the middle of the message checks that the frame is dropped rather than written and that the address counter does not skip a location.

// File: rtl/msg_loader_pkg.sv
package msg_loader_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_t;

  typedef enum logic [2:0] {
    PH_HDR_HI,
    PH_HDR_LO,
    PH_EVAL,
    PH_BODY,
    PH_DONE
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic shiftEn;
    logic bitClr;
    logic hiLd;
    logic loLd;
    logic wrPulse;
    logic errPulse;
    logic embedSet;
  } strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic lineBit;
    logic cntMid;
    logic cntEnd;
    logic lastBit;
    logic lenZero;
    logic lastByte;
  } status_t;

endpackage

// File: rtl/msg_loader_path.sv
module msg_loader_path
  import msg_loader_pkg::*;
#(
  parameter int MSG_DEPTH   = 8192,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = $clog2(MSG_DEPTH),
  localparam int LEN_W  = $clog2(MSG_DEPTH + 1),
  localparam int CNT_W  = $clog2(OVERSAMPLE),
  localparam int BIT_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  strobe_t           strb,
  output status_t           stat,
  output logic [ADDR_W-1:0] ramWrAddr,
  output logic [BYTE_W-1:0] ramWrData,
  output logic              ramWrEn,
  output logic              embedGo,
  output logic              frameErr
);

  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);
  localparam logic [LEN_W-1:0] LEN_MAX  = LEN_W'(MSG_DEPTH);

  // input synchronizer, idle level high
  logic [SYNC_STAGES-1:0] syncReg;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncReg <= '1;
        else       syncReg <= rxLine;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncReg <= '1;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], rxLine};
      end
    end
  endgenerate
  logic lineBit;
  assign lineBit = syncReg[SYNC_STAGES-1];

  // tick counter inside one bit period
  logic [CNT_W-1:0] tickCnt;
  always_ff @(posedge clk) begin
    if (!rstN)            tickCnt <= '0;
    else if (strb.cntClr) tickCnt <= '0;
    else if (strb.cntInc) tickCnt <= tickCnt + 1'b1;
  end

  // data bit index and shift register, LSB arrives first
  logic [BIT_W-1:0]  bitIdx;
  logic [BYTE_W-1:0] shiftReg;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx   <= '0;
      shiftReg <= '0;
    end else begin
      if (strb.bitClr)       bitIdx <= '0;
      else if (strb.shiftEn) bitIdx <= bitIdx + 1'b1;
      if (strb.shiftEn) shiftReg <= {lineBit, shiftReg[BYTE_W-1:1]};
    end
  end

  // length header with clamp to RAM depth
  logic [BYTE_W-1:0]   lenHi;
  logic [2*BYTE_W-1:0] lenRaw;
  logic [LEN_W-1:0]    lenReg;
  assign lenRaw = {lenHi, shiftReg};
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenHi  <= '0;
      lenReg <= '0;
    end else begin
      if (strb.hiLd) lenHi <= shiftReg;
      if (strb.loLd) begin
        if (32'(lenRaw) > MSG_DEPTH) lenReg <= LEN_MAX;
        else                         lenReg <= lenRaw[LEN_W-1:0];
      end
    end
  end

  // write counter and registered RAM port
  logic [LEN_W-1:0] wrCount;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCount   <= '0;
      ramWrEn   <= 1'b0;
      ramWrAddr <= '0;
      ramWrData <= '0;
    end else begin
      ramWrEn <= strb.wrPulse;
      if (strb.wrPulse) begin
        wrCount   <= wrCount + 1'b1;
        ramWrAddr <= wrCount[ADDR_W-1:0];
        ramWrData <= shiftReg;
      end
    end
  end

  // status flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      embedGo  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      frameErr <= strb.errPulse;
      if (strb.embedSet) embedGo <= 1'b1;
    end
  end

  always_comb begin
    stat.lineBit  = lineBit;
    stat.cntMid   = (tickCnt == CNT_MID);
    stat.cntEnd   = (tickCnt == CNT_END);
    stat.lastBit  = (bitIdx == BIT_LAST);
    stat.lenZero  = (lenReg == '0);
    stat.lastByte = (LEN_W'(wrCount + 1'b1) == lenReg);
  end

endmodule

// File: rtl/msg_loader_ctrl.sv
module msg_loader_ctrl
  import msg_loader_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sampleTick,
  input  status_t stat,
  output strobe_t strb
);

  rxState_t rxState, rxNext;
  phase_t   phase, phNext;
  logic     byteOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      phase   <= PH_HDR_HI;
    end else begin
      rxState <= rxNext;
      phase   <= phNext;
    end
  end

  // serial frame receiver
  always_comb begin
    rxNext        = rxState;
    byteOk        = 1'b0;
    strb          = '0;
    case (rxState)
      RX_IDLE: begin
        if (sampleTick && !stat.lineBit) begin
          strb.cntClr = 1'b1;
          rxNext      = RX_START;
        end
      end
      RX_START: begin
        if (sampleTick) begin
          if (stat.cntMid) begin
            strb.cntClr = 1'b1;
            strb.bitClr = 1'b1;
            rxNext      = stat.lineBit ? RX_IDLE : RX_DATA;
          end else begin
            strb.cntInc = 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (sampleTick) begin
          if (stat.cntEnd) begin
            strb.cntClr  = 1'b1;
            strb.shiftEn = 1'b1;
            if (stat.lastBit) rxNext = RX_STOP;
          end else begin
            strb.cntInc = 1'b1;
          end
        end
      end
      RX_STOP: begin
        if (sampleTick) begin
          if (stat.cntEnd) begin
            strb.cntClr = 1'b1;
            if (stat.lineBit) byteOk        = 1'b1;
            else              strb.errPulse = 1'b1;
            rxNext = RX_IDLE;
          end else begin
            strb.cntInc = 1'b1;
          end
        end
      end
      default: rxNext = RX_IDLE;
    endcase

    // framing of header and body
    phNext = phase;
    case (phase)
      PH_HDR_HI: if (byteOk) begin
        strb.hiLd = 1'b1;
        phNext    = PH_HDR_LO;
      end
      PH_HDR_LO: if (byteOk) begin
        strb.loLd = 1'b1;
        phNext    = PH_EVAL;
      end
      PH_EVAL: begin
        if (stat.lenZero) begin
          strb.embedSet = 1'b1;
          phNext        = PH_DONE;
        end else begin
          phNext = PH_BODY;
        end
      end
      PH_BODY: if (byteOk) begin
        strb.wrPulse = 1'b1;
        if (stat.lastByte) begin
          strb.embedSet = 1'b1;
          phNext        = PH_DONE;
        end
      end
      PH_DONE: phNext = PH_DONE;
      default: phNext = PH_HDR_HI;
    endcase
  end

endmodule

// File: rtl/msg_loader.sv
module msg_loader
  import msg_loader_pkg::*;
#(
  parameter int MSG_DEPTH   = 8192,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = $clog2(MSG_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              sampleTick,
  output logic [ADDR_W-1:0] ramWrAddr,
  output logic [7:0]        ramWrData,
  output logic              ramWrEn,
  output logic              embedGo,
  output logic              frameErr
);

  strobe_t strb;
  status_t stat;

  msg_loader_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .stat       (stat),
    .strb       (strb)
  );

  msg_loader_path #(
    .MSG_DEPTH   (MSG_DEPTH),
    .OVERSAMPLE  (OVERSAMPLE),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .rxLine    (rxLine),
    .strb      (strb),
    .stat      (stat),
    .ramWrAddr (ramWrAddr),
    .ramWrData (ramWrData),
    .ramWrEn   (ramWrEn),
    .embedGo   (embedGo),
    .frameErr  (frameErr)
  );

endmodule

// File: rtl/msg_loader_chk.sv
module msg_loader_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ramWrAddr,
  input logic              ramWrEn,
  input logic              embedGo,
  input logic              frameErr
);

  logic [ADDR_W-1:0] lastAddr;
  logic              seenWr;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastAddr <= '0;
      seenWr   <= 1'b0;
    end else if (ramWrEn) begin
      lastAddr <= ramWrAddr;
      seenWr   <= 1'b1;
    end
  end

  // R5: first write at address 0, then consecutive
  a_r5_first_addr: assert property (@(posedge clk) disable iff (!rstN)
    (ramWrEn && !seenWr) |-> (ramWrAddr == '0));
  a_r5_consecutive: assert property (@(posedge clk) disable iff (!rstN)
    (ramWrEn && seenWr) |-> (ramWrAddr == ADDR_W'(lastAddr + 1'b1)));
  // R5: one write cycle per byte
  a_r5_single_write: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |=> !ramWrEn);
  // R6: embed flag holds until reset
  a_r6_embed_sticky: assert property (@(posedge clk) disable iff (!rstN)
    embedGo |=> embedGo);
  // R10: no writes once embedding has started
  a_r10_no_late_write: assert property (@(posedge clk) disable iff (!rstN)
    embedGo |=> !ramWrEn);
  // R9: framing error is a single-cycle pulse and never a write
  a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);
  a_r9_err_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !(frameErr && ramWrEn));

endmodule

bind msg_loader msg_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ramWrAddr (ramWrAddr),
  .ramWrEn   (ramWrEn),
  .embedGo   (embedGo),
  .frameErr  (frameErr)
);

// File: tb/msg_loader_tb.sv
`timescale 1ns/1ps
module msg_loader_tb;

  localparam int DEPTH  = 8;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int TDIV   = 4;
  localparam int BITCLK = 16 * TDIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b1;
  logic sampleTick = 1'b0;
  logic [ADDR_W-1:0] ramWrAddr;
  logic [7:0] ramWrData;
  logic ramWrEn, embedGo, frameErr;

  int checks = 0;
  int errors = 0;
  int wrCnt = 0;
  int errCnt = 0;
  logic [ADDR_W-1:0] wAddr [0:63];
  logic [7:0]        wData [0:63];
  bit done = 1'b0;

  always #2 clk = ~clk;

  int tickDiv = 0;
  always @(posedge clk) begin
    tickDiv    <= (tickDiv == TDIV - 1) ? 0 : tickDiv + 1;
    sampleTick <= (tickDiv == TDIV - 1);
  end

  msg_loader #(.MSG_DEPTH(DEPTH)) u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .rxLine     (rxLine),
    .sampleTick (sampleTick),
    .ramWrAddr  (ramWrAddr),
    .ramWrData  (ramWrData),
    .ramWrEn    (ramWrEn),
    .embedGo    (embedGo),
    .frameErr   (frameErr)
  );

  // write and error monitor, sampled between edges
  always @(negedge clk) begin
    if (rstN && ramWrEn && wrCnt < 64) begin
      wAddr[wrCnt] = ramWrAddr;
      wData[wrCnt] = ramWrData;
      wrCnt = wrCnt + 1;
    end
    if (rstN && frameErr) errCnt = errCnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN   = 1'b0;
    rxLine = 1'b1;
    waitClk(6);
    rstN = 1'b1;
    waitClk(2);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit goodStop);
    rxLine = 1'b0;
    waitClk(BITCLK);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      waitClk(BITCLK);
    end
    rxLine = goodStop;
    waitClk(BITCLK);
    rxLine = 1'b1;
    waitClk(BITCLK);
  endtask

  task automatic sendHeader(input logic [15:0] len);
    sendByte(len[15:8], 1'b1);
    sendByte(len[7:0], 1'b1);
    waitClk(4);
  endtask

  task automatic testReset();
    applyReset();
    check(embedGo == 1'b0, "R1 embedGo", embedGo, 0);
    check(ramWrEn == 1'b0, "R1 ramWrEn", ramWrEn, 0);
    check(frameErr == 1'b0, "R1 frameErr", frameErr, 0);
  endtask

  task automatic testBasic();
    logic [7:0] msg [3] = '{8'h01, 8'h80, 8'hA5};
    int base;
    applyReset();
    base = wrCnt;
    sendHeader(16'h0003);
    check(wrCnt == base, "R4 header not written", wrCnt - base, 0);
    check(embedGo == 1'b0, "R6 low after header", embedGo, 0);
    sendByte(msg[0], 1'b1);
    sendByte(msg[1], 1'b1);
    check(embedGo == 1'b0, "R6 low before last byte", embedGo, 0);
    sendByte(msg[2], 1'b1);
    check(wrCnt - base == 3, "R5 write count", wrCnt - base, 3);
    for (int i = 0; i < 3; i++) begin
      check(wData[base+i] == msg[i], "R2 byte value LSB first", wData[base+i], msg[i]);
      check(int'(wAddr[base+i]) == i, "R5 address", wAddr[base+i], i);
    end
    check(embedGo == 1'b1, "R6 high after last byte", embedGo, 1);
    waitClk(20);
    check(embedGo == 1'b1, "R6 flag held", embedGo, 1);
  endtask

  task automatic testGlitch();
    int base;
    int eBase;
    applyReset();
    base  = wrCnt;
    eBase = errCnt;
    rxLine = 1'b0;
    waitClk(3 * TDIV);
    rxLine = 1'b1;
    waitClk(3 * BITCLK);
    sendHeader(16'h0001);
    check(wrCnt == base, "R3 glitch made no write", wrCnt - base, 0);
    sendByte(8'h5A, 1'b1);
    check(wrCnt - base == 1, "R3 one write after glitch", wrCnt - base, 1);
    check(wData[base] == 8'h5A, "R3 alignment kept", wData[base], 8'h5A);
    check(errCnt == eBase, "R3 no framing error", errCnt - eBase, 0);
    check(embedGo == 1'b1, "R6 single-byte message", embedGo, 1);
  endtask

  task automatic testZero();
    int base;
    applyReset();
    base = wrCnt;
    sendHeader(16'h0000);
    check(embedGo == 1'b1, "R7 embed after zero length", embedGo, 1);
    check(wrCnt == base, "R7 no write", wrCnt - base, 0);
  endtask

  task automatic testClamp();
    int base;
    applyReset();
    base = wrCnt;
    sendHeader(16'h0100);
    for (int i = 0; i < DEPTH - 1; i++) sendByte(8'(8'h10 + i), 1'b1);
    check(embedGo == 1'b0, "R8 not done one byte early", embedGo, 0);
    sendByte(8'h77, 1'b1);
    check(embedGo == 1'b1, "R8 done at depth", embedGo, 1);
    check(wrCnt - base == DEPTH, "R8 clamped count", wrCnt - base, DEPTH);
    check(int'(wAddr[base+DEPTH-1]) == DEPTH - 1, "R8 last address", wAddr[base+DEPTH-1], DEPTH - 1);
    sendByte(8'hEE, 1'b1);
    sendByte(8'hDD, 1'b1);
    check(wrCnt - base == DEPTH, "R10 no write after embed", wrCnt - base, DEPTH);
  endtask

  task automatic testFrameErr();
    int base;
    int eBase;
    applyReset();
    base  = wrCnt;
    eBase = errCnt;
    sendHeader(16'h0002);
    sendByte(8'h11, 1'b1);
    sendByte(8'h77, 1'b0);
    waitClk(BITCLK);
    check(errCnt - eBase == 1, "R9 one error pulse", errCnt - eBase, 1);
    check(wrCnt - base == 1, "R9 bad frame not written", wrCnt - base, 1);
    check(embedGo == 1'b0, "R9 bad frame not counted", embedGo, 0);
    sendByte(8'h22, 1'b1);
    check(wrCnt - base == 2, "R9 next frame written", wrCnt - base, 2);
    check(wData[base+1] == 8'h22, "R9 next frame data", wData[base+1], 8'h22);
    check(int'(wAddr[base+1]) == 1, "R9 address not skipped", wAddr[base+1], 1);
    check(embedGo == 1'b1, "R6 done after recovery", embedGo, 1);
  endtask

  initial begin
    testReset();
    testBasic();
    testGlitch();
    testZero();
    testClamp();
    testFrameErr();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule